// File: doc/BRIEF.md
# Three-Operand Video Min/Max Unit

This is an integer execution unit that runs one 64-bit instruction word against three 32-bit operands. In its first stage it picks the minimum or the maximum of operands A and B. Each operand carries its own signedness bit. The first stage can then clamp its result to the range of the destination type. In its second stage it combines that intermediate value with operand C. The second stage can write a half-word or byte into C, add the intermediate to C, run a second min/max against C, or pass the intermediate through unchanged. A min/max followed by another min/max gives a three-input minimum or maximum in one instruction.

Operand B comes from either a register input or an immediate input, chosen by a bit of the word. The unit only computes 32-bit operand formats with matching A/B signedness. Any other combination is flagged as unsupported and returns zero. Words that do not carry the unit's opcode are dropped. The result and its valid strobe come out one clock after the input strobe.

Top module: `mm3Top`

## Requirements
- R1: A word is accepted only when `inValid` is high and instruction bits 63:57 equal 7'b0011101. One cycle after an accepted word, `outValid` is high. Any other input gives `outValid` low in the next cycle, and `result` and `unsupported` keep their previous values.
- R2: After the active-low synchronous reset, `outValid`, `result` and `unsupported` are all zero.
- R3: Instruction bit 50 picks operand B. When it is 1, B is `opBReg`. When it is 0, B is `opBImm`.
- R4: Instruction bit 56 selects the first stage. When it is 1, the first stage takes the maximum of A and B. When it is 0, it takes the minimum. The comparison is signed two's complement when bits 48 (A) and 49 (B) are set, and unsigned when they are clear.
- R5: The format fields are bits 38:37 for A and 30:29 for B, and code 2'b11 means 32-bit. If either field is not 2'b11, or bit 48 differs from bit 49, the accepted word raises `unsupported` and `result` is zero.
- R6: When bit 55 is set, the first-stage value is clamped to the destination range, where bit 54 set means a signed destination. With an unsigned source and a signed destination, values above 0x7FFFFFFF become 0x7FFFFFFF. With a signed source and an unsigned destination, negative values become 0. With bit 55 clear, no clamping takes place.
- R7: Bits 53:51 select the second stage. Codes 0 to 3 are merges, and each keeps every other bit of C. Code 0 writes intermediate bits 15:0 into C bits 31:16. Code 1 writes them into C bits 15:0. Code 2 writes intermediate bits 7:0 into C bits 7:0. Code 3 writes them into C bits 23:16.
- R8: Second-stage code 4 outputs the intermediate plus C, modulo 2^32.
- R9: Second-stage code 5 outputs the minimum of the intermediate and C, and code 6 outputs the maximum. Both compare with the destination signedness (bit 54).
- R10: Second-stage code 7 outputs the intermediate unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands are present |
| instr | input | 64 | Instruction word |
| opA | input | 32 | Operand A |
| opBReg | input | 32 | Operand B, register form |
| opBImm | input | 32 | Operand B, immediate form |
| opC | input | 32 | Operand C for the second stage |
| outValid | output | 1 | Result is valid |
| result | output | 32 | Registered result |
| unsupported | output | 1 | Accepted word used an unsupported format or sign mix |

## Verification
Saturation only changes a value when the source and destination signedness differ. It must also meet a first-stage winner that is out of range, such as an unsigned value above 0x7FFFFFFF or a negative signed value. Random operands rarely line up like that together with the right bits. The stimulus therefore includes directed words that set bits 55 and 54 against the source signedness, with operands chosen so the out-of-range value wins the first compare. Random words with mostly legal formats then cover the mix of the second-stage codes against a behavioural model.

// File: rtl/mm3_pkg.sv
package mm3_pkg;
  localparam int DATA_W   = 32;
  localparam int INSTR_W  = 64;
  localparam int LANE_W   = 8;
  localparam int NUM_LANES = DATA_W / LANE_W;

  localparam int OPC_HI = 63;
  localparam int OPC_LO = 57;
  localparam int OPC_W  = OPC_HI - OPC_LO + 1;
  localparam logic [OPC_W-1:0] OPC_VAL = 7'b0011101;

  localparam int BIT_MAX    = 56;
  localparam int BIT_SAT    = 55;
  localparam int BIT_SDST   = 54;
  localparam int STG_LO     = 51;
  localparam int BIT_BREG   = 50;
  localparam int BIT_SB     = 49;
  localparam int BIT_SA     = 48;
  localparam int FMTA_LO    = 37;
  localparam int FMTB_LO    = 29;
  localparam logic [1:0] FMT_WORD = 2'b11;

  typedef enum logic [2:0] {
    STG_HALF_HI = 3'd0,
    STG_HALF_LO = 3'd1,
    STG_BYTE_0  = 3'd2,
    STG_BYTE_2  = 3'd3,
    STG_ADD     = 3'd4,
    STG_LESSER  = 3'd5,
    STG_GREATER = 3'd6,
    STG_PASS    = 3'd7
  } stage2Op_e;

  typedef struct packed {
    logic      accept;
    logic      badForm;
    logic      useBReg;
    logic      wantMax;
    logic      srcSigned;
    logic      dstSigned;
    logic      doClamp;
    stage2Op_e stage2;
  } mm3Ctrl_t;
endpackage

// File: rtl/mm3Ctrl.sv
module mm3Ctrl
  import mm3_pkg::*;
(
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  output mm3Ctrl_t           ctrl
);
  logic opcodeHit;
  logic [1:0] fmtA, fmtB;

  assign opcodeHit = (instr[OPC_HI:OPC_LO] == OPC_VAL);
  assign fmtA = instr[FMTA_LO+1:FMTA_LO];
  assign fmtB = instr[FMTB_LO+1:FMTB_LO];

  always_comb begin
    ctrl.accept    = inValid && opcodeHit;
    ctrl.badForm   = (fmtA != FMT_WORD) || (fmtB != FMT_WORD) ||
                     (instr[BIT_SA] != instr[BIT_SB]);
    ctrl.useBReg   = instr[BIT_BREG];
    ctrl.wantMax   = instr[BIT_MAX];
    ctrl.srcSigned = instr[BIT_SA];
    ctrl.dstSigned = instr[BIT_SDST];
    ctrl.doClamp   = instr[BIT_SAT];
    ctrl.stage2    = stage2Op_e'(instr[STG_LO+2:STG_LO]);
  end
endmodule

// File: rtl/mm3Datapath.sv
module mm3Datapath
  import mm3_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mm3Ctrl_t          ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opBReg,
  input  logic [DATA_W-1:0] opBImm,
  input  logic [DATA_W-1:0] opC,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              unsupported
);
  logic [DATA_W-1:0] opB, firstPick, clamped, mergeSrc, merged, secondPick, stageOut;
  logic aGreater, tGreater;
  logic [NUM_LANES-1:0] laneEn;

  // first stage
  assign opB = ctrl.useBReg ? opBReg : opBImm;
  assign aGreater = ctrl.srcSigned ? ($signed(opA) > $signed(opB)) : (opA > opB);
  assign firstPick = (aGreater == ctrl.wantMax) ? opA : opB;

  // clamp to destination range
  always_comb begin
    clamped = firstPick;
    if (ctrl.doClamp && firstPick[DATA_W-1]) begin
      if (ctrl.srcSigned && !ctrl.dstSigned)
        clamped = '0;
      else if (!ctrl.srcSigned && ctrl.dstSigned)
        clamped = {1'b0, {(DATA_W-1){1'b1}}};
    end
  end

  // merge lanes
  always_comb begin
    unique case (ctrl.stage2)
      STG_HALF_HI: laneEn = 4'b1100;
      STG_HALF_LO: laneEn = 4'b0011;
      STG_BYTE_0:  laneEn = 4'b0001;
      STG_BYTE_2:  laneEn = 4'b0100;
      default:     laneEn = '0;
    endcase
  end

  assign mergeSrc = (ctrl.stage2 == STG_HALF_HI || ctrl.stage2 == STG_HALF_LO)
                  ? {2{clamped[2*LANE_W-1:0]}}
                  : {NUM_LANES{clamped[LANE_W-1:0]}};

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    assign merged[g*LANE_W +: LANE_W] = laneEn[g] ? mergeSrc[g*LANE_W +: LANE_W]
                                                  : opC[g*LANE_W +: LANE_W];
  end

  // second-stage compare
  assign tGreater = ctrl.dstSigned ? ($signed(clamped) > $signed(opC)) : (clamped > opC);
  assign secondPick = (tGreater == (ctrl.stage2 == STG_GREATER)) ? clamped : opC;

  always_comb begin
    unique case (ctrl.stage2)
      STG_ADD:                 stageOut = clamped + opC;
      STG_LESSER, STG_GREATER: stageOut = secondPick;
      STG_PASS:                stageOut = clamped;
      default:                 stageOut = merged;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      result      <= '0;
      unsupported <= 1'b0;
    end else begin
      outValid <= ctrl.accept;
      if (ctrl.accept) begin
        unsupported <= ctrl.badForm;
        result      <= ctrl.badForm ? '0 : stageOut;
      end
    end
  end
endmodule

// File: rtl/mm3Top.sv
module mm3Top
  import mm3_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opBReg,
  input  logic [DATA_W-1:0]  opBImm,
  input  logic [DATA_W-1:0]  opC,
  output logic               outValid,
  output logic [DATA_W-1:0]  result,
  output logic               unsupported
);
  mm3Ctrl_t ctrl;

  mm3Ctrl uCtrl (
    .inValid(inValid),
    .instr  (instr),
    .ctrl   (ctrl)
  );

  mm3Datapath uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .opA        (opA),
    .opBReg     (opBReg),
    .opBImm     (opBImm),
    .opC        (opC),
    .outValid   (outValid),
    .result     (result),
    .unsupported(unsupported)
  );
endmodule

// File: rtl/mm3Checker.sv
module mm3Checker
  import mm3_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [INSTR_W-1:0] instr,
  input logic [DATA_W-1:0]  opC,
  input logic               outValid,
  input logic [DATA_W-1:0]  result,
  input logic               unsupported
);
  logic taken, legal;
  assign taken = inValid && (instr[OPC_HI:OPC_LO] == OPC_VAL);
  assign legal = (instr[FMTA_LO+1:FMTA_LO] == FMT_WORD) &&
                 (instr[FMTB_LO+1:FMTB_LO] == FMT_WORD) &&
                 (instr[BIT_SA] == instr[BIT_SB]);

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rstN)
    taken |=> outValid);

  p_drop_foreign_r1: assert property (@(posedge clk) disable iff (!rstN)
    !taken |=> (!outValid && $stable(result) && $stable(unsupported)));

  p_flag_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    unsupported |-> (result == '0));

  p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    (taken && !legal) |=> unsupported);

  p_merge_keeps_c_r7: assert property (@(posedge clk) disable iff (!rstN)
    (taken && legal && instr[STG_LO+2:STG_LO] == 3'd1)
      |=> (result[DATA_W-1:16] == $past(opC[DATA_W-1:16])));
endmodule

bind mm3Top mm3Checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .instr      (instr),
  .opC        (opC),
  .outValid   (outValid),
  .result     (result),
  .unsupported(unsupported)
);

// File: tb/tb_mm3Top.sv
module tb_mm3Top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] instr = '0;
  logic [31:0] opA = '0, opBReg = '0, opBImm = '0, opC = '0;
  logic        outValid;
  logic [31:0] result;
  logic        unsupported;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        expV = 1'b0;
  logic [31:0] expR = '0;
  logic        expU = 1'b0;

  always #10 clk = ~clk;

  mm3Top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .opA(opA), .opBReg(opBReg), .opBImm(opBImm), .opC(opC),
    .outValid(outValid), .result(result), .unsupported(unsupported)
  );

  function automatic logic [63:0] mk(input int stg, input bit mx, input bit sat,
                                     input bit sa, input bit sb, input bit sd,
                                     input bit breg, input int fa, input int fb);
    logic [63:0] w = '0;
    w[63:57] = 7'b0011101;
    w[56] = mx; w[55] = sat; w[54] = sd;
    w[53:51] = 3'(stg); w[50] = breg; w[49] = sb; w[48] = sa;
    w[38:37] = 2'(fa); w[30:29] = 2'(fb);
    return w;
  endfunction

  function automatic longint asVal(input logic [31:0] v, input bit s);
    return s ? longint'($signed(v)) : longint'({32'b0, v});
  endfunction

  task automatic model(input logic [63:0] w, input logic [31:0] a, input logic [31:0] br,
                       input logic [31:0] bi, input logic [31:0] c,
                       output logic [31:0] r, output logic u);
    longint va, vb, t, vt, vc;
    logic [31:0] b, t32;
    bit s = w[48];
    bit sd = w[54];
    u = (w[38:37] != 2'b11) || (w[30:29] != 2'b11) || (w[48] != w[49]);
    b = w[50] ? br : bi;
    va = asVal(a, s); vb = asVal(b, s);
    t = w[56] ? ((va > vb) ? va : vb) : ((va < vb) ? va : vb);
    if (w[55]) begin
      if (sd && t > 64'sd2147483647) t = 64'sd2147483647;
      if (!sd && t < 0) t = 0;
    end
    t32 = t[31:0];
    case (w[53:51])
      3'd0: r = {t32[15:0], c[15:0]};
      3'd1: r = {c[31:16], t32[15:0]};
      3'd2: r = {c[31:8], t32[7:0]};
      3'd3: r = {c[31:24], t32[7:0], c[15:0]};
      3'd4: r = t32 + c;
      3'd5, 3'd6: begin
        vt = asVal(t32, sd); vc = asVal(c, sd);
        if (w[53:51] == 3'd6) r = (vt > vc) ? t32 : c;
        else                  r = (vt < vc) ? t32 : c;
      end
      default: r = t32;
    endcase
    if (u) r = '0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit v, input logic [63:0] w,
                      input logic [31:0] a, input logic [31:0] br,
                      input logic [31:0] bi, input logic [31:0] c);
    logic [31:0] r; logic u;
    inValid = v; instr = w; opA = a; opBReg = br; opBImm = bi; opC = c;
    model(w, a, br, bi, c, r, u);
    expV = v && (w[63:57] == 7'b0011101);
    if (expV) begin expR = r; expU = u; end
    @(negedge clk);
    check(tag, 32'(outValid), 32'(expV), "outValid");
    check(tag, result, expR, "result");
    check(tag, 32'(unsupported), 32'(expU), "unsupported");
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", 32'(outValid), 0, "outValid in reset");
    check("R2", result, 0, "result in reset");
    check("R2", 32'(unsupported), 0, "unsupported in reset");
    rstN = 1'b1;

    // R4 signed/unsigned min and max, pass-through
    step("R4", 1, mk(7, 1, 0, 1, 1, 1, 1, 3, 3), 32'hFFFF_FFF0, 32'h5, 32'h0, 32'h0);
    step("R4", 1, mk(7, 1, 0, 0, 0, 0, 1, 3, 3), 32'hFFFF_FFF0, 32'h5, 32'h0, 32'h0);
    step("R4", 1, mk(7, 0, 0, 1, 1, 1, 1, 3, 3), 32'hFFFF_FFF0, 32'h5, 32'h0, 32'h0);
    step("R10", 1, mk(7, 0, 0, 0, 0, 0, 1, 3, 3), 32'h1234_5678, 32'h9000_0000, 32'h0, 32'hFFFF_FFFF);
    // R3 B source
    step("R3", 1, mk(7, 1, 0, 0, 0, 0, 0, 3, 3), 32'h10, 32'h5, 32'h80, 32'h0);
    step("R3", 1, mk(7, 1, 0, 0, 0, 0, 1, 3, 3), 32'h10, 32'h5, 32'h80, 32'h0);
    // R1 foreign words and idle cycles
    step("R1", 1, 64'h0, 32'h1, 32'h2, 32'h3, 32'h4);
    step("R1", 0, mk(4, 1, 0, 0, 0, 0, 1, 3, 3), 32'h1, 32'h2, 32'h3, 32'h4);
    step("R1", 1, mk(4, 1, 0, 0, 0, 0, 1, 3, 3) ^ 64'h0200_0000_0000_0000, 32'h1, 32'h2, 32'h3, 32'h4);
    // R6 saturation
    step("R6", 1, mk(7, 1, 1, 0, 0, 1, 1, 3, 3), 32'hF000_0000, 32'h1, 32'h0, 32'h0);
    step("R6", 1, mk(7, 0, 1, 1, 1, 0, 1, 3, 3), 32'h8000_0000, 32'h1, 32'h0, 32'h0);
    step("R6", 1, mk(7, 0, 0, 1, 1, 0, 1, 3, 3), 32'h8000_0000, 32'h1, 32'h0, 32'h0);
    step("R6", 1, mk(7, 1, 1, 1, 1, 1, 1, 3, 3), 32'h8000_0000, 32'h7FFF_FFFF, 32'h0, 32'h0);
    // R7 merges
    for (int k = 0; k < 4; k++)
      step("R7", 1, mk(k, 1, 0, 0, 0, 0, 1, 3, 3), 32'hA1B2_C3D4, 32'h0, 32'h0, 32'h1122_3344);
    // R8 accumulate with wrap
    step("R8", 1, mk(4, 1, 0, 0, 0, 0, 1, 3, 3), 32'hFFFF_FFF0, 32'h0, 32'h0, 32'h20);
    // R9 second min/max with destination sign
    step("R9", 1, mk(5, 1, 0, 0, 0, 1, 1, 3, 3), 32'h8000_0000, 32'h0, 32'h0, 32'h5);
    step("R9", 1, mk(6, 1, 0, 0, 0, 1, 1, 3, 3), 32'h8000_0000, 32'h0, 32'h0, 32'h5);
    step("R9", 1, mk(6, 1, 0, 0, 0, 0, 1, 3, 3), 32'h8000_0000, 32'h0, 32'h0, 32'h5);
    step("R9", 1, mk(5, 1, 0, 1, 1, 0, 1, 3, 3), 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h5);
    // R5 unsupported
    step("R5", 1, mk(7, 1, 0, 1, 0, 0, 1, 3, 3), 32'h55, 32'h1, 32'h0, 32'h0);
    step("R5", 1, mk(7, 1, 0, 0, 0, 0, 1, 2, 3), 32'h55, 32'h1, 32'h0, 32'h0);
    step("R5", 1, mk(7, 1, 0, 0, 0, 0, 1, 3, 0), 32'h55, 32'h1, 32'h0, 32'h0);
    step("R1", 0, 64'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    step("R5", 1, mk(7, 1, 0, 0, 0, 0, 1, 3, 3), 32'h55, 32'h1, 32'h0, 32'h0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] w;
      bit s = 1'($urandom);
      w = mk($urandom % 8, 1'($urandom), 1'($urandom), s,
             ($urandom % 10 == 0) ? !s : s, 1'($urandom), 1'($urandom),
             ($urandom % 10 == 0) ? ($urandom % 4) : 3,
             ($urandom % 10 == 0) ? ($urandom % 4) : 3);
      if ($urandom % 8 == 0) w[63:57] = 7'($urandom);
      step("R7", ($urandom % 6) != 0, w, $urandom, $urandom, $urandom, $urandom);
    end

    // R2 reset mid-stream
    rstN = 1'b0;
    @(negedge clk);
    check("R2", 32'(outValid), 0, "outValid after reset");
    check("R2", result, 0, "result after reset");
    check("R2", 32'(unsupported), 0, "unsupported after reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule